// File: doc/BRIEF.md
# Byte-Laned EDO DRAM Device Emulator

This block is a synthesizable stand-in for an asynchronous x16 extended-data-out DRAM. It sits on a fast system clock and watches the memory's active-low strobes: a row strobe, separate low-byte and high-byte column strobes, a write strobe and an output enable. It also watches a 10-bit multiplexed address bus. A small parameterized array behind it holds the data. The shared 16-bit data bus is split into an input, an output and a two-bit per-byte drive enable, and the enclosing pad ring turns these into a tri-state pin set.

The emulator latches the row half of the address when the row strobe falls and the column half when the first column strobe falls. It then performs reads, byte-only accesses, early writes and late writes. It applies the output-enable rules of an EDO part, including the rule that parks the outputs until the next column cycle. A row strobe with no column strobe is a refresh and leaves the data alone. The pins are sampled on each rising clock edge, and the outputs change at the edge that samples the causing pin change.

Top module: `edo_dram_emu`

## Requirements
- R1: After reset every stored word reads as zero and `dqOe` is 2'b00.
- R2: The row is taken from `addr[ROW_BITS-1:0]` at the edge where `rasN` is first seen low. The column is taken from `addr[COL_BITS-1:0]` at the edge where the first column strobe is seen low. The word index is {row, column}. Higher address bits have no effect.
- R3: `caslN` selects the low lane (`dq[7:0]`, `dqOe[0]`) and `cashN` selects the high lane (`dq[15:8]`, `dqOe[1]`). A read drives only the strobed lanes, and a write changes only the strobed lanes.
- R4: A column strobe falling with `weN` high and `oeN` low drives the stored word of the addressed location from that edge on.
- R5: A lane strobe falling while `weN` is low writes `dqIn` into that lane at that edge (early write). The outputs then stay off whatever the level of `oeN`.
- R6: A falling `weN` while column strobes are low and `oeN` is high writes the lanes that are low, using `dqIn` as sampled at that edge (late write).
- R7: A falling `weN` while column strobes are low and `oeN` is low writes nothing, and the outputs keep driving the stored word.
- R8: Read data stays driven after the column strobes rise while `rasN` is low. It is released at the edge where `rasN` and both column strobes are seen high.
- R9: `oeN` high turns the outputs off at the next edge. When no column strobe is low, `oeN` returning low drives the outputs again.
- R10: `oeN` seen high while a column strobe is held low after its fall keeps the outputs off until the next column-strobe fall, even if `oeN` returns low.
- R11: A cycle with `rasN` low and no column strobe drives nothing and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe, active low |
| caslN | input | 1 | Low-lane column strobe, active low |
| cashN | input | 1 | High-lane column strobe, active low |
| weN | input | 1 | Write strobe, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| dqIn | input | 16 | Data from the shared bus |
| dqOut | output | 16 | Data to the shared bus |
| dqOe | output | 2 | Per-lane drive enable, bit 0 low byte |

## Verification
The hardest situation to reach from the ports is the parked-output state, in which `oeN` is pulsed high while a column strobe is held low and then returns low. The bench walks that sequence step by step and confirms that the outputs stay off even though every strobe level would otherwise allow a read. It then confirms that a second column fall in the same row brings the outputs back. The blocked late write is reached in a similar way: `weN` is lowered after the column fall with `oeN` kept low, and a later read of the same word confirms that it is unchanged.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int ADDR_W = 10;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DQ_W   = LANE_W * LANES;

  typedef struct packed {
    logic             loadRow;
    logic             loadCol;
    logic [LANES-1:0] wrLanes;
  } edoStrobes_t;
endpackage

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rasN,
  input  logic             caslN,
  input  logic             cashN,
  input  logic             weN,
  input  logic             oeN,
  output edoStrobes_t      strobes,
  output logic [LANES-1:0] laneOe
);
  logic             rasNPrev;
  logic             weNPrev;
  logic             oeNReg;
  logic [LANES-1:0] laneLowPrev;
  logic             readValid;
  logic             oeLock;
  logic [LANES-1:0] laneSel;

  logic [LANES-1:0] laneLow;
  logic [LANES-1:0] laneFall;
  logic             casLow;
  logic             casFall;
  logic             weFall;
  logic             rowOpen;
  logic             idle;
  logic [LANES-1:0] wrNow;

  always_comb begin
    laneLow  = ~{cashN, caslN};
    laneFall = laneLow & ~laneLowPrev;
    casLow   = |laneLow;
    casFall  = casLow & ~(|laneLowPrev);
    weFall   = weNPrev & ~weN;
    rowOpen  = ~rasN;
    idle     = rasN & ~casLow;
    wrNow    = '0;
    if (rowOpen) begin
      wrNow = (laneFall & {LANES{~weN}})
            | (laneLow & ~laneFall & {LANES{weFall & oeN}});
    end
    strobes.loadRow = rasNPrev & ~rasN;
    strobes.loadCol = rowOpen & casFall;
    strobes.wrLanes = wrNow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rasNPrev    <= 1'b1;
      weNPrev     <= 1'b1;
      oeNReg      <= 1'b1;
      laneLowPrev <= '0;
    end else begin
      rasNPrev    <= rasN;
      weNPrev     <= weN;
      oeNReg      <= oeN;
      laneLowPrev <= laneLow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      readValid <= 1'b0;
      oeLock    <= 1'b0;
      laneSel   <= '0;
    end else if (idle) begin
      readValid <= 1'b0;
      oeLock    <= 1'b0;
      laneSel   <= '0;
    end else if (strobes.loadCol) begin
      readValid <= weN;
      oeLock    <= 1'b0;
      laneSel   <= laneFall;
    end else begin
      if (|wrNow) readValid <= 1'b0;
      if (casLow && oeN) oeLock <= 1'b1;
      if (rowOpen) laneSel <= laneSel | laneFall;
    end
  end

  assign laneOe = {LANES{readValid & ~oeNReg & ~oeLock}} & laneSel;
endmodule

// File: rtl/edo_datapath.sv
module edo_datapath
  import edo_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dqIn,
  input  edoStrobes_t       strobes,
  output logic [DQ_W-1:0]   rdData
);
  localparam int IDX_W = ROW_BITS + COL_BITS;
  localparam int DEPTH = 1 << IDX_W;
  localparam int TOP_B = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;

  logic [ROW_BITS-1:0] rowReg;
  logic [COL_BITS-1:0] colReg;
  logic [IDX_W-1:0]    wrIdx;
  logic [IDX_W-1:0]    rdIdx;
  logic                unusedAddrBits;

  assign unusedAddrBits = ^addr[ADDR_W-1:TOP_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowReg <= '0;
      colReg <= '0;
    end else begin
      if (strobes.loadRow) rowReg <= addr[ROW_BITS-1:0];
      if (strobes.loadCol) colReg <= addr[COL_BITS-1:0];
    end
  end

  assign wrIdx = {rowReg, strobes.loadCol ? addr[COL_BITS-1:0] : colReg};
  assign rdIdx = {rowReg, colReg};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) laneMem[i] <= '0;
      end else if (strobes.wrLanes[g]) begin
        laneMem[wrIdx] <= dqIn[g*LANE_W +: LANE_W];
      end
    end
    assign rdData[g*LANE_W +: LANE_W] = laneMem[rdIdx];
  end
endmodule

// File: rtl/edo_dram_emu.sv
module edo_dram_emu
  import edo_pkg::*;
#(
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rasN,
  input  logic              caslN,
  input  logic              cashN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dqIn,
  output logic [DQ_W-1:0]   dqOut,
  output logic [LANES-1:0]  dqOe
);
  edoStrobes_t strobes;

  edo_ctrl uCtrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rasN   (rasN),
    .caslN  (caslN),
    .cashN  (cashN),
    .weN    (weN),
    .oeN    (oeN),
    .strobes(strobes),
    .laneOe (dqOe)
  );

  edo_datapath #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) uData (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (addr),
    .dqIn   (dqIn),
    .strobes(strobes),
    .rdData (dqOut)
  );
endmodule

// File: rtl/edo_dram_chk.sv
module edo_dram_chk
  import edo_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             rasN,
  input logic             caslN,
  input logic             cashN,
  input logic             weN,
  input logic             oeN,
  input logic [LANES-1:0] dqOe,
  input logic [LANES-1:0] wrLanes
);
  // R5
  early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rasN && $past(caslN) && $past(cashN) && !(caslN && cashN) && !weN)
      |=> (dqOe == '0));

  // R7
  late_write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wrLanes) && (caslN == $past(caslN)) && (cashN == $past(cashN))) |-> oeN);

  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oeN |=> (dqOe == '0));

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rasN && caslN && cashN) |=> (dqOe == '0));

  // R11
  refresh_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (caslN && cashN) |-> (wrLanes == '0));
endmodule

bind edo_dram_emu edo_dram_chk uChk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rasN   (rasN),
  .caslN  (caslN),
  .cashN  (cashN),
  .weN    (weN),
  .oeN    (oeN),
  .dqOe   (dqOe),
  .wrLanes(strobes.wrLanes)
);

// File: tb/tb_edo_dram_emu.sv
`timescale 1ns/1ps
module tb_edo_dram_emu;
  localparam int ROW_BITS = 3;
  localparam int COL_BITS = 3;
  localparam int DEPTH    = 1 << (ROW_BITS + COL_BITS);
  localparam int ROWS     = 1 << ROW_BITS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rasN = 1'b1, caslN = 1'b1, cashN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [9:0]  addr = '0;
  logic [15:0] dqIn = '0;
  logic [15:0] dqOut;
  logic [1:0]  dqOe;

  logic [15:0] expMem [DEPTH];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  edo_dram_emu #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) dut (
    .clk(clk), .rst_n(rst_n), .rasN(rasN), .caslN(caslN), .cashN(cashN),
    .weN(weN), .oeN(oeN), .addr(addr), .dqIn(dqIn), .dqOut(dqOut), .dqOe(dqOe)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] rowA(int idx, int junk);
    return 10'((junk << ROW_BITS) | (idx >> COL_BITS));
  endfunction

  function automatic logic [9:0] colA(int idx, int junk);
    return 10'((junk << COL_BITS) | (idx & ((1 << COL_BITS) - 1)));
  endfunction

  function automatic logic [15:0] laneMask(logic [1:0] lanes);
    return {{8{lanes[1]}}, {8{lanes[0]}}};
  endfunction

  task automatic earlyWrite(int idx, logic [15:0] d, logic [1:0] lanes);
    rasN = 0; addr = rowA(idx, idx * 5 + 3); tick();
    addr = colA(idx, idx * 7 + 1); weN = 0; oeN = 0; dqIn = d;
    caslN = ~lanes[0]; cashN = ~lanes[1]; tick();
    check("R5 early write outputs off", {14'b0, dqOe}, 16'h0);
    caslN = 1; cashN = 1; weN = 1; rasN = 1; oeN = 1; tick();
    expMem[idx] = (expMem[idx] & ~laneMask(lanes)) | (d & laneMask(lanes));
  endtask

  task automatic readWord(int idx, logic [1:0] lanes, string req);
    rasN = 0; addr = rowA(idx, idx + 11); tick();
    addr = colA(idx, idx * 3 + 9); weN = 1; oeN = 0;
    caslN = ~lanes[0]; cashN = ~lanes[1]; tick();
    check({req, " lanes driven"}, {14'b0, dqOe}, {14'b0, lanes});
    check({req, " data"}, dqOut & laneMask(lanes), expMem[idx] & laneMask(lanes));
    caslN = 1; cashN = 1; tick();
    check("R8 EDO hold after CAS rise", {14'b0, dqOe}, {14'b0, lanes});
    rasN = 1; tick();
    check("R8 release when idle", {14'b0, dqOe}, 16'h0);
    oeN = 1; tick();
  endtask

  task automatic lateWrite(int idx, logic [15:0] d, bit oeLow);
    rasN = 0; addr = rowA(idx, 2); tick();
    addr = colA(idx, 6); weN = 1; oeN = oeLow ? 1'b0 : 1'b1;
    caslN = 0; cashN = 0; tick();
    weN = 0; dqIn = d; tick();
    if (oeLow) begin
      check("R7 blocked late write keeps driving", {14'b0, dqOe}, 16'h0003);
      check("R7 blocked late write data", dqOut, expMem[idx]);
    end else begin
      expMem[idx] = d;
      check("R6 late write outputs off", {14'b0, dqOe}, 16'h0);
    end
    caslN = 1; cashN = 1; weN = 1; rasN = 1; oeN = 1; tick();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stimulus
    for (int i = 0; i < DEPTH; i++) expMem[i] = '0;
    repeat (3) tick();
    rst_n = 1; tick();
    check("R1 reset outputs off", {14'b0, dqOe}, 16'h0);
    readWord(0, 2'b11, "R1 reset contents");
    readWord(DEPTH - 1, 2'b11, "R1 reset contents");

    // R2 R4 R5: full-word early write then read of every location
    for (int i = 0; i < DEPTH; i++) earlyWrite(i, 16'(i * 16'h0f1 ^ 16'h5a3c), 2'b11);
    for (int i = 0; i < DEPTH; i++) readWord(i, 2'b11, "R2 R4 full read");

    // R3: byte-only writes and byte-only reads
    for (int i = 0; i < DEPTH; i += 3) earlyWrite(i, 16'(i * 16'h1357 + 16'h2468), 2'b01);
    for (int i = 1; i < DEPTH; i += 3) earlyWrite(i, 16'(i * 16'h0b0d ^ 16'hc3a5), 2'b10);
    for (int i = 0; i < DEPTH; i++) begin
      readWord(i, 2'b01, "R3 low lane read");
      readWord(i, 2'b10, "R3 high lane read");
    end

    // R6 / R7: late writes
    lateWrite(5, 16'hbeef, 1'b0);
    readWord(5, 2'b11, "R6 late write stored");
    lateWrite(6, 16'hdead, 1'b1);
    readWord(6, 2'b11, "R7 blocked write left word");

    // R10: OE pulse during CAS low parks the outputs
    rasN = 0; addr = rowA(9, 4); tick();
    addr = colA(9, 1); weN = 1; oeN = 0; caslN = 0; cashN = 0; tick();
    check("R4 read drives", {14'b0, dqOe}, 16'h0003);
    oeN = 1; tick();
    check("R9 OE high turns off", {14'b0, dqOe}, 16'h0);
    oeN = 0; tick();
    check("R10 parked after OE pulse", {14'b0, dqOe}, 16'h0);
    caslN = 1; cashN = 1; tick();
    check("R10 parked after CAS rise", {14'b0, dqOe}, 16'h0);
    addr = colA(10, 2); caslN = 0; cashN = 0; tick();
    check("R10 next CAS fall drives", {14'b0, dqOe}, 16'h0003);
    check("R10 next CAS data", dqOut, expMem[10]);
    // R9: OE toggle with no CAS low
    caslN = 1; cashN = 1; tick();
    check("R8 hold", {14'b0, dqOe}, 16'h0003);
    oeN = 1; tick();
    check("R9 OE high during hold", {14'b0, dqOe}, 16'h0);
    oeN = 0; tick();
    check("R9 OE low drives again", {14'b0, dqOe}, 16'h0003);
    rasN = 1; tick();
    check("R8 idle release", {14'b0, dqOe}, 16'h0);
    oeN = 1; tick();

    // R11: RAS-only refresh of every row
    for (int r = 0; r < ROWS; r++) begin
      rasN = 0; oeN = 0; weN = 0; addr = 10'(r); dqIn = 16'hffff; tick();
      check("R11 refresh drives nothing", {14'b0, dqOe}, 16'h0);
      tick();
      rasN = 1; oeN = 1; weN = 1; tick();
    end
    for (int i = 0; i < DEPTH; i++) readWord(i, 2'b11, "R11 data kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule